// File: doc/BRIEF.md
# Real-Time Clock Register Block

This block keeps wall-clock time of day as three packed-decimal bytes: seconds, minutes and hours. It advances them once per second, counting one second as a fixed number of pulses on a base tick-enable input. Sixteen byte-wide registers sit behind a small address/data port. They hold the time, three alarm bytes, five plain calendar bytes and four status/control registers. A single interrupt line reports alarm matches, completed updates and a programmable periodic event.

Each one-second advance is preceded by a short update window, which software sees as a busy bit. The time changes in the same cycle that the window closes. A control bit halts updates so that software can load a new time safely. Event flags stay set until software reads the flag register, and that read also clears them.

Top module: `rtc_regs`

## Requirements
- R1: After reset, register 0xA reads 0x26, register 0xB reads 0x02, register 0xC reads 0x00, register 0xD reads 0x80, and `irq` is low.
- R2: Each update advances the time in packed decimal (upper nibble tens, lower nibble units) at addresses 0x0 (seconds), 0x2 (minutes) and 0x4 (hours), carrying 59 seconds into minutes and 59 minutes into hours. 23:59:59 becomes 00:00:00 with no carry into any calendar byte.
- R3: When updates are running, an update starts every TICKS_PER_SEC base ticks. Register 0xA bit 7 reads 1 for exactly UIP_CYCLES clock cycles, and the time takes its new value in the cycle this bit returns to 0.
- R4: While register 0xB bit 7 (halt) is 1, no update window opens and the time bytes change only through writes. Clearing the bit resumes updates.
- R5: Register 0xB bit 4 (update-done interrupt enable) reads 0 whenever bit 7 is 1, whatever value was written. For example, writing 0xFD reads back 0xED.
- R6: At each update, if the new time equals the alarm bytes at 0x1 (seconds), 0x3 (minutes) and 0x5 (hours), register 0xC bit 5 is set. Otherwise bit 5 is left unchanged.
- R7: Every completed update sets register 0xC bit 4.
- R8: When register 0xA bits 3:0 hold a rate r other than 0, register 0xC bit 6 is set once every 2^(r-1) base ticks. Rate 0 produces no periodic events.
- R9: Register 0xC bit 7 and `irq` are high exactly when a flag in 0xC bits 6:4 is set and the enable at the same position in register 0xB (bit 6 periodic, bit 5 alarm, bit 4 update-done) is also set.
- R10: A read of register 0xC returns the flags and then clears them. An event that arrives in the same cycle as the read stays set.
- R11: Register 0xD always reads 0x80 and ignores writes. Register 0xA bit 7 is read-only, and bits 6:0 store what is written.
- R12: Addresses 0x6 to 0x9 and 0xE are plain byte storage, and address 0xF reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_tick | input | 1 | One-cycle enable from the oscillator divider |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe for `wr_data` into `addr` |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; needed for the clear-on-read side effect |
| rd_data | output | 8 | Combinational read data of `addr` |
| irq | output | 1 | Interrupt request, level |

## Verification
The bench builds the block with TICKS_PER_SEC at 16 and UIP_CYCLES at 3, and holds `base_tick` high. One second therefore lasts 16 clock cycles. This lets the bench step the time across every decimal carry, including the end-of-day wrap, through dozens of updates. It can also measure both the exact width of the busy window and the spacing between windows. With each tick lasting one clock, a periodic rate of 1 raises an event on every edge, which exercises the collision between a clearing read and a new event.

// File: rtl/rtc_regs.sv
module rtc_regs #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_CYCLES    = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       base_tick,
  input  logic [3:0] addr,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       irq
);

  localparam int TW = $clog2(TICKS_PER_SEC);
  localparam int UW = $clog2(UIP_CYCLES + 1);
  localparam int DW = 16;

  localparam logic [3:0] AD_SEC = 4'h0, AD_SECAL = 4'h1, AD_MIN = 4'h2, AD_MINAL = 4'h3;
  localparam logic [3:0] AD_HR = 4'h4, AD_HRAL = 4'h5, AD_WDAY = 4'h6, AD_DAY = 4'h7;
  localparam logic [3:0] AD_MON = 4'h8, AD_YR = 4'h9, AD_CTLA = 4'hA, AD_CTLB = 4'hB;
  localparam logic [3:0] AD_FLAG = 4'hC, AD_VALID = 4'hD, AD_CENT = 4'hE;

  logic [7:0]    sc, mn, hr, sc_al, mn_al, hr_al;
  logic [7:0]    wday, day, mon, yr, cent;
  logic [6:0]    ctl_a;
  logic [7:0]    ctl_b;
  logic [2:0]    flg;
  logic          uip;
  logic [UW-1:0] uip_cnt;
  logic [TW-1:0] tick_cnt;
  logic [DW-1:0] div_cnt;

  function automatic logic [7:0] bcd_step(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  logic       s_wrap, m_wrap;
  logic [7:0] sc_n, mn_n, hr_n;
  assign s_wrap = (sc == 8'h59);
  assign m_wrap = (mn == 8'h59);
  assign sc_n   = s_wrap ? 8'h00 : bcd_step(sc);
  assign mn_n   = !s_wrap ? mn : (m_wrap ? 8'h00 : bcd_step(mn));
  assign hr_n   = !(s_wrap && m_wrap) ? hr : ((hr == 8'h23) ? 8'h00 : bcd_step(hr));

  logic          halt, sec_edge, upd_fire, alarm_hit, per_evt, rd_c;
  logic [3:0]    rate;
  logic [DW-1:0] per_mask;
  logic [2:0]    pend;

  assign halt      = ctl_b[7];
  assign sec_edge  = base_tick && (tick_cnt == TW'(TICKS_PER_SEC - 1));
  assign upd_fire  = uip && (uip_cnt == UW'(1)) && !halt;
  assign alarm_hit = ({hr_n, mn_n, sc_n} == {hr_al, mn_al, sc_al});
  assign rate      = ctl_a[3:0];
  assign per_mask  = (rate == 4'd0) ? '0 : ((DW'(1) << (rate - 4'd1)) - DW'(1));
  assign per_evt   = base_tick && (rate != 4'd0) && ((div_cnt & per_mask) == per_mask);
  assign rd_c      = rd_en && (addr == AD_FLAG);
  assign pend      = flg & ctl_b[6:4];
  assign irq       = |pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sc <= '0; mn <= '0; hr <= '0;
      sc_al <= '0; mn_al <= '0; hr_al <= '0;
      wday <= '0; day <= '0; mon <= '0; yr <= '0; cent <= '0;
      ctl_a <= 7'h26;
      ctl_b <= 8'h02;
      flg <= '0;
      uip <= 1'b0;
      uip_cnt <= '0;
      tick_cnt <= '0;
      div_cnt <= '0;
    end else begin
      if (base_tick) begin
        tick_cnt <= sec_edge ? '0 : tick_cnt + TW'(1);
        div_cnt  <= div_cnt + DW'(1);
      end

      if (halt) begin
        uip <= 1'b0;
      end else if (uip) begin
        if (uip_cnt == UW'(1)) uip <= 1'b0;
        uip_cnt <= uip_cnt - UW'(1);
      end else if (sec_edge) begin
        uip     <= 1'b1;
        uip_cnt <= UW'(UIP_CYCLES);
      end

      if (upd_fire) begin
        sc <= sc_n; mn <= mn_n; hr <= hr_n;
      end

      flg <= (rd_c ? 3'b000 : flg) | {per_evt, upd_fire && alarm_hit, upd_fire};

      if (wr_en) begin
        case (addr)
          AD_SEC:   sc    <= wr_data;
          AD_SECAL: sc_al <= wr_data;
          AD_MIN:   mn    <= wr_data;
          AD_MINAL: mn_al <= wr_data;
          AD_HR:    hr    <= wr_data;
          AD_HRAL:  hr_al <= wr_data;
          AD_WDAY:  wday  <= wr_data;
          AD_DAY:   day   <= wr_data;
          AD_MON:   mon   <= wr_data;
          AD_YR:    yr    <= wr_data;
          AD_CTLA:  ctl_a <= wr_data[6:0];
          AD_CTLB:  ctl_b <= wr_data[7] ? (wr_data & 8'hEF) : wr_data;
          AD_CENT:  cent  <= wr_data;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      AD_SEC:   rd_data = sc;
      AD_SECAL: rd_data = sc_al;
      AD_MIN:   rd_data = mn;
      AD_MINAL: rd_data = mn_al;
      AD_HR:    rd_data = hr;
      AD_HRAL:  rd_data = hr_al;
      AD_WDAY:  rd_data = wday;
      AD_DAY:   rd_data = day;
      AD_MON:   rd_data = mon;
      AD_YR:    rd_data = yr;
      AD_CTLA:  rd_data = {uip, ctl_a};
      AD_CTLB:  rd_data = ctl_b;
      AD_FLAG:  rd_data = {irq, flg, 4'h0};
      AD_VALID: rd_data = 8'h80;
      AD_CENT:  rd_data = cent;
      default:  rd_data = 8'h00;
    endcase
  end

  logic [UW:0] uip_age;
  always_ff @(posedge clk) begin
    if (!rst_n) uip_age <= '0;
    else        uip_age <= uip ? uip_age + (UW+1)'(1) : '0;
  end

  assert_uip_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    uip |-> (int'(uip_age) < UIP_CYCLES));

  assert_halt_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !wr_en) |=> $stable({hr, mn, sc}));

  assert_halt_no_uip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !uip);

  assert_ue_forced_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !ctl_b[4]);

  assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_fire && !wr_en && sc == 8'h59) |=> (sc == 8'h00));

  assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && !upd_fire && !per_evt) |=> (flg == 3'b000));

  assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flg != 3'b000));

endmodule

// File: tb/rtc_regs_test.sv
module rtc_regs_test;
  localparam int TPS = 16;
  localparam int UIPC = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       base_tick = 1'b1;
  logic [3:0] addr = 4'h0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rtc_regs #(.TICKS_PER_SEC(TPS), .UIP_CYCLES(UIPC)) uut (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq(irq));

  // {start hh, mm, ss, expected hh, mm, ss}
  localparam logic [47:0] VEC [8] = '{
    48'h000000_000001, 48'h000009_000010, 48'h000059_000100, 48'h005959_010000,
    48'h095959_100000, 48'h123456_123457, 48'h195959_200000, 48'h235959_000000};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rd_data;
    @(posedge clk);
    #1 rd_en = 1'b0;
  endtask

  task automatic wait_update(output bit ok);
    logic [7:0] v;
    int n;
    ok = 0; n = 0;
    rd(4'hA, v);
    while (!v[7] && n < 100) begin rd(4'hA, v); n++; end
    if (!v[7]) return;
    n = 0;
    while (v[7] && n < 100) begin rd(4'hA, v); n++; end
    ok = !v[7];
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] a, b, c, d, e;
    bit ok;
    int hi, lo, cnt;
    bit seen;

    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    rd(4'hA, a); rd(4'hB, b); rd(4'hC, c); rd(4'hD, d);
    chk("R1 reset regs A,B,C,D", {a, b, c, d}, 32'h2602_0080);
    chk("R1 reset irq", irq, 0);

    wr(4'hB, 8'h82);
    wr(4'hA, 8'h20);
    rd(4'hC, c);
    wr(4'hA, 8'hFF); rd(4'hA, a);
    chk("R11 reg A bit7 read-only", a, 8'h7F);
    wr(4'hA, 8'h20); rd(4'hA, a);
    chk("R11 reg A stores rate 0", a, 8'h20);
    wr(4'hD, 8'h00); rd(4'hD, d);
    chk("R11 reg D fixed", d, 8'h80);
    rd(4'hC, c);

    wr(4'h6, 8'h03); wr(4'h7, 8'h15); wr(4'h8, 8'h12); wr(4'h9, 8'h24); wr(4'hE, 8'h20);
    rd(4'h6, a); rd(4'h7, b); rd(4'h8, c); rd(4'h9, d); rd(4'hE, e);
    chk("R12 calendar storage", {a, b, c, d}, 32'h0315_1224);
    chk("R12 century storage", e, 8'h20);
    rd(4'hF, a);
    chk("R12 unused address", a, 8'h00);

    wr(4'hB, 8'hFD); rd(4'hB, b);
    chk("R5 halt write clears bit4", b, 8'hED);
    wr(4'hB, 8'h12); wr(4'hB, 8'h92); rd(4'hB, b);
    chk("R5 bit4 forced low", b, 8'h82);

    for (int i = 0; i < 8; i++) begin
      wr(4'h0, VEC[i][31:24]); wr(4'h2, VEC[i][39:32]); wr(4'h4, VEC[i][47:40]);
      wr(4'hB, 8'h02);
      wait_update(ok);
      wr(4'hB, 8'h82);
      rd(4'h4, a); rd(4'h2, b); rd(4'h0, c);
      chk("R3 update window seen", ok, 1);
      chk("R2 BCD step", {a, b, c}, VEC[i][23:0]);
    end
    rd(4'h7, b);
    chk("R2 no carry into day", b, 8'h15);

    wr(4'hB, 8'h02);
    rd(4'hA, a); cnt = 0;
    while (!a[7] && cnt < 100) begin rd(4'hA, a); cnt++; end
    hi = 0; lo = 0;
    while (a[7] && hi < 100) begin hi++; rd(4'hA, a); end
    while (!a[7] && lo < 100) begin lo++; rd(4'hA, a); end
    wr(4'hB, 8'h82);
    chk("R3 busy width", hi, UIPC);
    chk("R3 update spacing", hi + lo, TPS);

    wr(4'h0, 8'h11); wr(4'h2, 8'h11); wr(4'h4, 8'h11);
    seen = 0;
    for (int i = 0; i < 48; i++) begin
      rd(4'hA, a);
      if (a[7]) seen = 1;
    end
    chk("R4 no busy while halted", seen, 0);
    rd(4'h4, a); rd(4'h2, b); rd(4'h0, c);
    chk("R4 time frozen", {a, b, c}, 24'h111111);

    rd(4'hC, c);
    wr(4'h0, 8'h30); wr(4'h2, 8'h20); wr(4'h4, 8'h10);
    wr(4'h1, 8'h31); wr(4'h3, 8'h20); wr(4'h5, 8'h10);
    wr(4'hB, 8'h22);
    wait_update(ok);
    wr(4'hB, 8'hA2);
    @(negedge clk); #1;
    chk("R6 R9 alarm irq", irq, 1);
    rd(4'hC, c);
    chk("R6 R9 alarm flags", c, 8'hB0);
    rd(4'hC, c);
    chk("R10 flags cleared", c, 8'h00);
    @(negedge clk); #1;
    chk("R10 irq dropped", irq, 0);

    wr(4'h0, 8'h00); wr(4'h2, 8'h00); wr(4'h4, 8'h05);
    wr(4'hB, 8'h22);
    wait_update(ok);
    wr(4'hB, 8'hA2);
    @(negedge clk); #1;
    chk("R6 no match no irq", irq, 0);
    rd(4'hC, c);
    chk("R6 R7 no match flags", c, 8'h10);

    wr(4'hB, 8'h12);
    wait_update(ok);
    @(negedge clk); #1;
    chk("R7 R9 update irq", irq, 1);
    rd(4'hC, c);
    chk("R7 update flags", c, 8'h90);
    rd(4'hC, c);
    chk("R10 cleared after read", c, 8'h00);
    wr(4'hB, 8'h82);

    wr(4'hB, 8'hC2);
    wr(4'hA, 8'h23);
    rd(4'hA, a);
    chk("R11 rate stored", a, 8'h23);
    rd(4'hC, c);
    cnt = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk); #1;
      addr = 4'hC;
      if (irq) begin rd_en = 1'b1; cnt++; end
      else rd_en = 1'b0;
    end
    @(posedge clk); #1 rd_en = 1'b0;
    chk("R8 periodic count rate 3", cnt, 16);

    wr(4'hA, 8'h21);
    rd(4'hC, c);
    chk("R8 rate 1 flags", c, 8'hC0);
    rd(4'hC, c);
    chk("R10 same-cycle event survives", c, 8'hC0);

    wr(4'hA, 8'h20);
    rd(4'hC, c); rd(4'hC, c);
    repeat (40) @(posedge clk);
    rd(4'hC, c);
    chk("R8 rate 0 silent", c, 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule